// File: doc/BRIEF.md
# SPI Relay Driver Register Interface

This block is the digital front end of an eight-channel low-side relay driver. A host talks to it as an SPI slave in mode 0, with an active-low chip select. Each 16-bit command carries an access flag, a six-bit register address and a data byte. The block keeps one output command register and two pin-mapping registers, and it reports a read-only status byte.

Each of the eight channel enables is the OR of three sources: the host's command bit, input pin 0 gated by its mapping mask, and input pin 1 gated by its mapping mask. A local relay can therefore follow a hardware pin without any SPI traffic. Each transfer is full duplex. While the host shifts in a command, the block shifts out the register that the previous frame selected. The block also checks every frame for a legal clock count and records the result in an error flag.

All SPI lines and input pins are sampled in the system clock domain, so SCLK must run well below the system clock. The SPI lines are a plain serial link with no valid/ready handshake, and the host paces every transfer. There is no back-pressure: the block keeps up with any SCLK that leaves at least four system clocks in each SCLK phase.

Top module: `relay_spi_ctrl`

## Requirements
- R1: A frame is 16 bits, most significant bit first. Bit 15 = 1 means write and 0 means read. Bit 14 is reserved, bits 13:8 are the address and bits 7:0 are the data. A valid write to address 0x00 loads the output command register, and command bit n turns channel n on.
- R2: After reset, the command register is 0x00, mapping mask 0 (address 0x04) is 0x04, mapping mask 1 (address 0x05) is 0x08 and the error flag is 1.
- R3: The first frame after reset shifts out the status word 0x06, 0x80 | pins, where pins = {pin1, pin0}.
- R4: Every reply word is {2'b00, address, data}, and it is shifted out MSB first on MISO. A valid read frame selects its address for the next reply. A write frame or an invalid frame selects the status address 0x06.
- R5: A frame is valid when it has at least 16 SCLK rising edges and the count is a multiple of 8. At every CS rising edge, status bit 7 is set to 0 for a valid frame and to 1 for any other count.
- R6: An invalid frame changes no register.
- R7: Status (address 0x06) is read-only, and a write to it is ignored. Bit 7 holds the error flag, bits 6:2 are 0, and bits 1:0 are the synchronised levels of pin 1 and pin 0.
- R8: A write to an unmapped address changes nothing. A read of an unmapped address returns data 0x00 with that address echoed.
- R9: The enable for channel n is the OR of command bit n, (pin 0 AND mask-0 bit n) and (pin 1 AND mask-1 bit n).
- R10: Each input pin passes through two synchronising flip-flops, so a pin change reaches ch_en two clocks later. A register write reaches ch_en three clocks after CS rises.
- R11: MISO is 0 while CS is high. MISO changes only after SCLK falling edges (mode 0).
- R12: In a frame longer than 16 bits, the last 16 bits received form the command. The bits shifted out after the first 16 are the earliest bits received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | SPI serial clock, idles low |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial reply to the host |
| in0_pin | input | 1 | External control pin 0 |
| in1_pin | input | 1 | External control pin 1 |
| ch_en | output | 8 | Channel enables |

## Verification
The bench uses the default parameters: two synchroniser stages and a counting unit of 8 bits. With these values the two-clock pin latency and the three-clock write latency can be checked exactly against a behavioural model on every clock. The bench sends frames of 8, 16, 20, 24 and 32 clocks, which covers short, odd-multiple and chained lengths. These frame lengths exercise both the saturating part and the modulo part of the clock-count check.

// File: rtl/relay_spi_pkg.sv
package relay_spi_pkg;
  localparam int FRAME_W = 16;
  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 6;
  localparam int PIN_N   = 2;
  localparam int CMD_W   = 1 + ADDR_W + DATA_W;

  localparam logic [ADDR_W-1:0] ADR_CMD  = 6'b0000_00;
  localparam logic [ADDR_W-1:0] ADR_MSK0 = 6'b0001_00;
  localparam logic [ADDR_W-1:0] ADR_MSK1 = 6'b0001_01;
  localparam logic [ADDR_W-1:0] ADR_STAT = 6'b0001_10;

  localparam logic [DATA_W-1:0] MSK0_RST = 8'h04;
  localparam logic [DATA_W-1:0] MSK1_RST = 8'h08;

  typedef struct packed {
    logic              wr;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } cmd_t;
endpackage

// File: rtl/relay_sync.sv
module relay_sync #(
  parameter int           W       = 1,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg <= {STAGES{RST_VAL}};
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/relay_spi_shifter.sv
module relay_spi_shifter
  import relay_spi_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int UNIT_W      = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               spi_sclk,
  input  logic               spi_cs_n,
  input  logic               spi_mosi,
  input  logic [FRAME_W-1:0] reply_word,
  output logic               spi_miso,
  output logic               frame_done,
  output logic               frame_ok,
  output logic [CMD_W-1:0]   frame_cmd
);
  localparam int CNT_W = $clog2(FRAME_W + 1);
  localparam int MOD_W = $clog2(UNIT_W);

  logic [2:0] line_s;
  logic sclk_s, cs_s, mosi_s, sclk_q, cs_q;
  logic sck_rise, sck_fall, cs_fall, cs_rise;
  logic [FRAME_W-1:0] shreg;
  logic mosi_bit;
  logic [CNT_W-1:0] full_cnt;
  logic [MOD_W-1:0] mod_cnt;

  relay_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_line_sync (
    .clk(clk), .rst_n(rst_n), .d({spi_sclk, spi_cs_n, spi_mosi}), .q(line_s)
  );

  assign sclk_s   = line_s[2];
  assign cs_s     = line_s[1];
  assign mosi_s   = line_s[0];
  assign sck_rise = sclk_s & ~sclk_q;
  assign sck_fall = ~sclk_s & sclk_q;
  assign cs_fall  = ~cs_s & cs_q;
  assign cs_rise  = cs_s & ~cs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q   <= 1'b0;
      cs_q     <= 1'b1;
      shreg    <= '0;
      mosi_bit <= 1'b0;
      full_cnt <= '0;
      mod_cnt  <= '0;
    end else begin
      sclk_q <= sclk_s;
      cs_q   <= cs_s;
      if (cs_fall) begin
        shreg    <= reply_word;
        full_cnt <= '0;
        mod_cnt  <= '0;
      end else if (!cs_s) begin
        if (sck_rise) begin
          mosi_bit <= mosi_s;
          if (full_cnt != CNT_W'(FRAME_W)) full_cnt <= full_cnt + 1'b1;
          mod_cnt <= (mod_cnt == MOD_W'(UNIT_W - 1)) ? '0 : mod_cnt + 1'b1;
        end
        if (sck_fall) shreg <= {shreg[FRAME_W-2:0], mosi_bit};
      end
    end
  end

  assign frame_done = cs_rise;
  assign frame_ok   = (full_cnt == CNT_W'(FRAME_W)) && (mod_cnt == '0);
  assign frame_cmd  = {shreg[FRAME_W-1], shreg[FRAME_W-3:0]};
  assign spi_miso   = ~cs_s & shreg[FRAME_W-1];

  // R3: the reply word is captured when the frame opens
  assert_reply_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall |=> (shreg == $past(reply_word)));
endmodule

// File: rtl/relay_spi_regs.sv
module relay_spi_regs
  import relay_spi_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_done,
  input  logic               frame_ok,
  input  logic [CMD_W-1:0]   frame_cmd,
  input  logic [PIN_N-1:0]   pins_s,
  output logic [DATA_W-1:0]  cmd_bits,
  output logic [DATA_W-1:0]  msk0_bits,
  output logic [DATA_W-1:0]  msk1_bits,
  output logic [FRAME_W-1:0] reply_word
);
  cmd_t f;
  logic err_q;
  logic [ADDR_W-1:0] sel_q;
  logic [DATA_W-1:0] rd_data, stat_byte;

  assign f = frame_cmd;
  assign stat_byte = {err_q, {(DATA_W-1-PIN_N){1'b0}}, pins_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_bits  <= '0;
      msk0_bits <= MSK0_RST;
      msk1_bits <= MSK1_RST;
      err_q     <= 1'b1;
      sel_q     <= ADR_STAT;
    end else if (frame_done) begin
      err_q <= ~frame_ok;
      sel_q <= ADR_STAT;
      if (frame_ok) begin
        if (f.wr) begin
          case (f.addr)
            ADR_CMD:  cmd_bits  <= f.data;
            ADR_MSK0: msk0_bits <= f.data;
            ADR_MSK1: msk1_bits <= f.data;
            default:  ;
          endcase
        end else begin
          sel_q <= f.addr;
        end
      end
    end
  end

  always_comb begin
    case (sel_q)
      ADR_CMD:  rd_data = cmd_bits;
      ADR_MSK0: rd_data = msk0_bits;
      ADR_MSK1: rd_data = msk1_bits;
      ADR_STAT: rd_data = stat_byte;
      default:  rd_data = '0;
    endcase
    reply_word = {{(FRAME_W-ADDR_W-DATA_W){1'b0}}, sel_q, rd_data};
  end

  // R5: a bad clock count leaves the error flag set in the status reply
  assert_bad_count_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !frame_ok) |=> reply_word[DATA_W-1] && (sel_q == ADR_STAT));
  // R6: a bad frame leaves every register as it was
  assert_bad_frame_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !frame_ok) |=> $stable(cmd_bits) && $stable(msk0_bits) && $stable(msk1_bits));
  // R7: reserved status bits always read zero
  assert_stat_rsv_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q == ADR_STAT) |-> (reply_word[DATA_W-2:PIN_N] == '0));
  // R8: an unmapped or read-only target is never written
  assert_unmapped_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && f.wr && f.addr != ADR_CMD && f.addr != ADR_MSK0 && f.addr != ADR_MSK1)
      |=> $stable(cmd_bits) && $stable(msk0_bits) && $stable(msk1_bits));
endmodule

// File: rtl/relay_chmap.sv
module relay_chmap
  import relay_spi_pkg::*;
(
  input  logic [DATA_W-1:0] cmd_bits,
  input  logic [DATA_W-1:0] msk0_bits,
  input  logic [DATA_W-1:0] msk1_bits,
  input  logic [PIN_N-1:0]  pins_s,
  output logic [DATA_W-1:0] ch_en
);
  for (genvar ch = 0; ch < DATA_W; ch++) begin : g_ch
    assign ch_en[ch] = cmd_bits[ch] | (pins_s[0] & msk0_bits[ch]) | (pins_s[1] & msk1_bits[ch]);
  end
endmodule

// File: rtl/relay_spi_ctrl.sv
module relay_spi_ctrl
  import relay_spi_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int UNIT_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sclk,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  input  logic              in0_pin,
  input  logic              in1_pin,
  output logic [DATA_W-1:0] ch_en
);
  logic [PIN_N-1:0]   pins_s;
  logic [FRAME_W-1:0] reply_word;
  logic [CMD_W-1:0]   frame_cmd;
  logic               frame_done, frame_ok;
  logic [DATA_W-1:0]  cmd_bits, msk0_bits, msk1_bits;

  relay_sync #(.W(PIN_N), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_pin_sync (
    .clk(clk), .rst_n(rst_n), .d({in1_pin, in0_pin}), .q(pins_s)
  );

  relay_spi_shifter #(.SYNC_STAGES(SYNC_STAGES), .UNIT_W(UNIT_W)) u_shifter (
    .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .reply_word(reply_word), .spi_miso(spi_miso),
    .frame_done(frame_done), .frame_ok(frame_ok), .frame_cmd(frame_cmd)
  );

  relay_spi_regs u_regs (
    .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .frame_ok(frame_ok),
    .frame_cmd(frame_cmd), .pins_s(pins_s), .cmd_bits(cmd_bits),
    .msk0_bits(msk0_bits), .msk1_bits(msk1_bits), .reply_word(reply_word)
  );

  relay_chmap u_chmap (
    .cmd_bits(cmd_bits), .msk0_bits(msk0_bits), .msk1_bits(msk1_bits),
    .pins_s(pins_s), .ch_en(ch_en)
  );

  // R9: a commanded channel is always enabled
  assert_cmd_forces_on_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((ch_en & cmd_bits) == cmd_bits));
endmodule

// File: tb/relay_spi_ctrl_bench.sv
module relay_spi_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0, in0 = 1'b0, in1 = 1'b0;
  logic miso;
  logic [7:0] ch_en;

  int total = 0, bad = 0;

  logic [7:0]  m_cmd = 8'h00, m_msk0 = 8'h04, m_msk1 = 8'h08;
  logic        m_err = 1'b1;
  logic [5:0]  m_sel = 6'b000110;
  logic [1:0]  p1 = 2'b00, p2 = 2'b00;
  int          pend = 0, cs_hi = 0;
  logic [15:0] pend_cmd = '0;
  bit          pend_ok = 0;

  relay_spi_ctrl u_relay_spi_ctrl (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso), .in0_pin(in0), .in1_pin(in1), .ch_en(ch_en)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic void apply_frame();
    logic [5:0] a = pend_cmd[13:8];
    m_err = !pend_ok;
    m_sel = 6'b000110;
    if (pend_ok) begin
      if (pend_cmd[15]) begin
        if (a == 6'b000000) m_cmd = pend_cmd[7:0];
        else if (a == 6'b000100) m_msk0 = pend_cmd[7:0];
        else if (a == 6'b000101) m_msk1 = pend_cmd[7:0];
      end else begin
        m_sel = a;
      end
    end
  endfunction

  function automatic logic [15:0] exp_reply();
    logic [7:0] d;
    case (m_sel)
      6'b000000: d = m_cmd;
      6'b000100: d = m_msk0;
      6'b000101: d = m_msk1;
      6'b000110: d = {m_err, 5'b00000, p2};
      default:   d = 8'h00;
    endcase
    return {2'b00, m_sel, d};
  endfunction

  // behavioural reference: pin delay line and delayed register update
  always @(posedge clk) begin
    if (!rst_n) begin
      p1 = 2'b00; p2 = 2'b00;
    end else begin
      p2 = p1; p1 = {in1, in0};
      if (pend > 0) begin
        pend = pend - 1;
        if (pend == 0) apply_frame();
      end
    end
    cs_hi = cs_n ? cs_hi + 1 : 0;
  end

  // every-clock comparison against the reference
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R9/R10 ch_en", {24'h0, ch_en},
          {24'h0, m_cmd | (p2[0] ? m_msk0 : 8'h00) | (p2[1] ? m_msk1 : 8'h00)});
      if (cs_hi >= 3) chk("R11 miso idle", {31'h0, miso}, 32'h0);
    end
  end

  task automatic xfer(input string req, input logic [31:0] tx, input int n);
    logic [31:0] rx = '0;
    logic [15:0] expw = exp_reply();
    int k;
    @(negedge clk) cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = n - 1; i >= 0; i--) begin
      mosi = tx[i];
      repeat (HALF) @(negedge clk);
      rx = {rx[30:0], miso};
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    pend_cmd = tx[15:0];
    pend_ok = (n >= 16) && (n % 8 == 0);
    pend = 3;
    k = (n < 16) ? n : 16;
    chk(req, (rx >> (n - k)) & ((32'h1 << k) - 1), {16'h0, expw} >> (16 - k));
    if (n == 24) chk("R12 trailing echo", {24'h0, rx[7:0]}, {24'h0, tx[23:16]});
    repeat (2 * HALF) @(negedge clk);
  endtask

  function automatic logic [15:0] wr(input logic [5:0] a, input logic [7:0] d);
    return {1'b1, 1'b0, a, d};
  endfunction
  function automatic logic [15:0] rd(input logic [5:0] a);
    return {1'b0, 1'b0, a, 8'h00};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2 reset enables", {24'h0, ch_en}, 32'h00);
    in0 = 1'b1; repeat (3) @(negedge clk);
    chk("R2 mask0 default", {24'h0, ch_en}, 32'h04);
    in1 = 1'b1; repeat (3) @(negedge clk);
    chk("R2 mask1 default", {24'h0, ch_en}, 32'h0C);
    in0 = 1'b0; repeat (3) @(negedge clk);

    xfer("R3 first reply status", {16'h0, wr(6'h00, 8'h81)}, 16);
    chk("R1 command applied", {24'h0, ch_en}, 32'h89);
    xfer("R4 write returns status", {16'h0, rd(6'h04)}, 16);
    xfer("R4 read mask0", {16'h0, rd(6'h00)}, 16);
    xfer("R4 read command", {16'h0, wr(6'h05, 8'h30)}, 16);
    chk("R9 mask1 routing", {24'h0, ch_en}, 32'hB1);
    in1 = 1'b0; in0 = 1'b1; repeat (4) @(negedge clk);
    xfer("R5 status ok", {16'h0, wr(6'h00, 8'hFF)}, 20);
    chk("R6 bad frame no write", {24'h0, ch_en}, 32'h85);
    xfer("R5 status after 20", {16'h0, wr(6'h04, 8'hFF)}, 8);
    xfer("R5 status after 8", {8'h0, 8'hA5, wr(6'h00, 8'h0F)}, 24);
    chk("R12 chained write", {24'h0, ch_en}, 32'h0F);
    xfer("R5 status after 24", {16'hC35A, rd(6'h05)}, 32);
    xfer("R7 read mask1", {16'h0, wr(6'h06, 8'hFF)}, 16);
    xfer("R7 status after write", {16'h0, wr(6'h08, 8'hFF)}, 16);
    xfer("R8 status after unmapped wr", {16'h0, rd(6'h08)}, 16);
    xfer("R8 unmapped read zero", {16'h0, rd(6'h00)}, 16);
    xfer("R8 command kept", {16'h0, rd(6'h06)}, 16);
    xfer("R7 status pins", {16'h0, rd(6'h00)}, 16);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    total++; bad++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule